// File: doc/BRIEF.md
# Deferred-Fault Commit Unit

This block keeps the deferred-fault state of a register file and carries out the two operations that settle it: commit and clear-flag. Each register has one deferred-fault (NE) flag. There is one flag vector for integer registers and a separate one for float registers. Next to the flag vectors sits a small table of logging slots. When logging is active, each slot records which register a deferred fault targets, whether that register is a float register, and the faulting address.

An operation names either one target register or, with the "all" selector set, every available register. The lower half of the register set and the upper half each have their own availability input. Both operations clear the chosen NE flags. A clear-flag operation also invalidates the matching logging slots when logging is active. A commit does the same only if it found a deferred fault pending, and in that case it also raises a one-cycle commit exception. A record port sets a flag and, while logging is active, fills a slot. This lets the surrounding pipeline report new deferred faults.

Top module: `dfc_commit_unit`

## Requirements
- R1: After reset both flag vectors are zero, every slot is invalid with its float bit, register and address fields all zero, and `commit_exc` is low.
- R2: In a cycle with `rec_valid` high and `op_valid` low, bit `rec_reg` is set in `ne_fp` if `rec_float` is 1, otherwise in `ne_int`. A record is ignored in any cycle in which `op_valid` is high.
- R3: An accepted record with logging active (`log_valid` and `log_enable` both 1) fills the lowest-numbered invalid slot with its float bit, register and address. If all slots are valid, no slot changes and the flag is still set. If logging is inactive, no slot is written.
- R4: For an operation with `op_all` = 0, only bit `op_reg` of the selected vector is cleared. The selected vector is `ne_fp` when `op_float` is 1 and `ne_int` otherwise.
- R5: For an operation with `op_all` = 1, registers 0..NREG/2-1 form the lower half, gated by `lo_avail`, and the remaining registers form the upper half, gated by `hi_avail`. Each available half of the selected vector is zeroed and each unavailable half is kept.
- R6: With logging active, a clear-flag operation (`op_commit` = 0) invalidates every valid slot whose float bit equals `op_float` and whose register equals `op_reg`, or every such slot regardless of register when `op_all` = 1. An invalidated slot has its float bit, register and address set to zero. A commit does the same only when a fault is pending.
- R7: A commit is pending when, for `op_all` = 0, the target's flag is set, or, for `op_all` = 1, any available half of the selected vector is nonzero. A pending commit with logging active drives `commit_exc` high for exactly the one cycle after the operation.
- R8: A commit with nothing pending, or any operation while logging is inactive, leaves every slot unchanged and raises no exception. The flags are still cleared.
- R9: An operation with `tgt_ok` = 0 makes no change to flags or slots and raises no exception.
- R10: An operation never changes the flag vector of the other register type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request this cycle |
| op_commit | input | 1 | 1 = commit, 0 = clear-flag |
| op_float | input | 1 | Operation acts on float registers |
| op_all | input | 1 | Act on all available registers instead of `op_reg` |
| op_reg | input | RW | Target register index |
| tgt_ok | input | 1 | Target register is available |
| hi_avail | input | 1 | Upper register half is available |
| lo_avail | input | 1 | Lower register half is available |
| log_valid | input | 1 | Logging control is valid |
| log_enable | input | 1 | Logging is enabled |
| rec_valid | input | 1 | Record a new deferred fault |
| rec_float | input | 1 | Recorded fault targets a float register |
| rec_reg | input | RW | Recorded destination register |
| rec_addr | input | AW | Recorded faulting address |
| ne_int | output | NREG | Integer NE flag vector |
| ne_fp | output | NREG | Float NE flag vector |
| slot_valid | output | NSLOT | Slot valid bits |
| slot_float | output | NSLOT | Slot float bits |
| slot_reg | output | NSLOT*RW | Slot destination registers, slot 0 in the low bits |
| slot_addr | output | NSLOT*AW | Slot addresses, slot 0 in the low bits |
| commit_exc | output | 1 | One-cycle commit exception pulse |

## Verification
The assertions assume that every input is known and steady between rising edges. The bench therefore changes inputs only on the falling edge. They also assume that a record and an operation in the same cycle resolve in favour of the operation. The stimulus issues such collisions on purpose so that the ignored record can be seen on the flag outputs. Register indices come from a small set that straddles the half boundary and both ends of the range. Availability and logging controls are toggled freely so that masked halves, an unavailable target and a full slot table all occur.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

  typedef enum logic {
    DFC_CLEAR  = 1'b0,
    DFC_COMMIT = 1'b1
  } dfc_op_e;

  // Slot selection rule for invalidation; register fields are zero-extended to 8 bits.
  function automatic logic slot_hit(input logic vld, input logic flt, input logic [7:0] reg_i,
                                    input logic op_flt, input logic all, input logic [7:0] tgt);
    return vld && (flt == op_flt) && (all || (reg_i == tgt));
  endfunction

endpackage

// File: rtl/dfc_flag_bank.sv
module dfc_flag_bank #(
  parameter int NREG = 64,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [RW-1:0]   set_idx,
  input  logic            clr_en,
  input  logic [NREG-1:0] clr_mask,
  output logic [NREG-1:0] flags
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else if (clr_en) flags <= flags & ~clr_mask;
    else if (set_en) flags[set_idx] <= 1'b1;
  end

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((flags & $past(clr_mask)) == '0));

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> flags[$past(set_idx)]);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(flags));

endmodule

// File: rtl/dfc_slot_table.sv
module dfc_slot_table
  import dfc_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int RW    = 6,
  parameter int AW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic              alloc_float,
  input  logic [RW-1:0]     alloc_reg,
  input  logic [AW-1:0]     alloc_addr,
  input  logic              kill_en,
  input  logic              kill_float,
  input  logic              kill_all,
  input  logic [RW-1:0]     kill_reg,
  output logic [NSLOT-1:0]  slot_valid,
  output logic [NSLOT-1:0]  slot_float,
  output logic [NSLOT*RW-1:0] slot_reg,
  output logic [NSLOT*AW-1:0] slot_addr
);

  logic [NSLOT-1:0] grant;
  logic [NSLOT-1:0] hit;

  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (!slot_valid[i] && !taken) begin
        grant[i] = 1'b1;
        taken = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign hit[i] = slot_hit(slot_valid[i], slot_float[i], 8'(slot_reg[i*RW +: RW]),
                             kill_float, kill_all, 8'(kill_reg));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_valid[i]          <= 1'b0;
        slot_float[i]          <= 1'b0;
        slot_reg[i*RW +: RW]   <= '0;
        slot_addr[i*AW +: AW]  <= '0;
      end else if (kill_en && hit[i]) begin
        slot_valid[i]          <= 1'b0;
        slot_float[i]          <= 1'b0;
        slot_reg[i*RW +: RW]   <= '0;
        slot_addr[i*AW +: AW]  <= '0;
      end else if (alloc_en && grant[i]) begin
        slot_valid[i]          <= 1'b1;
        slot_float[i]          <= alloc_float;
        slot_reg[i*RW +: RW]   <= alloc_reg;
        slot_addr[i*AW +: AW]  <= alloc_addr;
      end
    end
  end

  assert_grant_R3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));

  assert_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !kill_en && (&slot_valid)) |=> $stable(slot_valid));

  assert_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kill_en |=> (($past(hit) & slot_valid) == '0));

  assert_kill_shrink_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_en && !alloc_en) |=> ($countones(slot_valid) <= $countones($past(slot_valid))));

endmodule

// File: rtl/dfc_commit_unit.sv
module dfc_commit_unit
  import dfc_pkg::*;
#(
  parameter int NREG  = 64,
  parameter int NSLOT = 4,
  parameter int AW    = 32,
  localparam int RW   = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic                op_commit,
  input  logic                op_float,
  input  logic                op_all,
  input  logic [RW-1:0]       op_reg,
  input  logic                tgt_ok,
  input  logic                hi_avail,
  input  logic                lo_avail,
  input  logic                log_valid,
  input  logic                log_enable,
  input  logic                rec_valid,
  input  logic                rec_float,
  input  logic [RW-1:0]       rec_reg,
  input  logic [AW-1:0]       rec_addr,
  output logic [NREG-1:0]     ne_int,
  output logic [NREG-1:0]     ne_fp,
  output logic [NSLOT-1:0]    slot_valid,
  output logic [NSLOT-1:0]    slot_float,
  output logic [NSLOT*RW-1:0] slot_reg,
  output logic [NSLOT*AW-1:0] slot_addr,
  output logic                commit_exc
);

  localparam int HALF = NREG / 2;

  function automatic logic pending_of(input logic [NREG-1:0] v, input logic all,
                                      input logic [RW-1:0] idx, input logic hi, input logic lo);
    if (!all) return v[idx];
    return (hi && (|v[NREG-1:HALF])) || (lo && (|v[HALF-1:0]));
  endfunction

  function automatic logic [NREG-1:0] mask_of(input logic all, input logic [RW-1:0] idx,
                                              input logic hi, input logic lo);
    logic [NREG-1:0] m;
    m = '0;
    if (!all) m[idx] = 1'b1;
    else begin
      if (hi) m[NREG-1:HALF] = {(NREG-HALF){1'b1}};
      if (lo) m[HALF-1:0]    = {HALF{1'b1}};
    end
    return m;
  endfunction

  dfc_op_e          op_kind;
  logic             op_go;
  logic             log_act;
  logic             rec_go;
  logic             pend_hit;
  logic             slot_kill;
  logic             exc_d;
  logic [NREG-1:0]  sel_vec;
  logic [NREG-1:0]  clr_mask;

  assign op_kind   = dfc_op_e'(op_commit);
  assign op_go     = op_valid && tgt_ok;
  assign log_act   = log_valid && log_enable;
  assign rec_go    = rec_valid && !op_valid;
  assign sel_vec   = op_float ? ne_fp : ne_int;
  assign pend_hit  = pending_of(sel_vec, op_all, op_reg, hi_avail, lo_avail);
  assign clr_mask  = mask_of(op_all, op_reg, hi_avail, lo_avail);
  assign slot_kill = op_go && log_act && ((op_kind == DFC_CLEAR) || pend_hit);
  assign exc_d     = op_go && log_act && (op_kind == DFC_COMMIT) && pend_hit;

  dfc_flag_bank #(.NREG(NREG)) u_int_bank (
    .clk(clk), .rst_n(rst_n),
    .set_en(rec_go && !rec_float), .set_idx(rec_reg),
    .clr_en(op_go && !op_float), .clr_mask(clr_mask),
    .flags(ne_int)
  );

  dfc_flag_bank #(.NREG(NREG)) u_fp_bank (
    .clk(clk), .rst_n(rst_n),
    .set_en(rec_go && rec_float), .set_idx(rec_reg),
    .clr_en(op_go && op_float), .clr_mask(clr_mask),
    .flags(ne_fp)
  );

  dfc_slot_table #(.NSLOT(NSLOT), .RW(RW), .AW(AW)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(rec_go && log_act), .alloc_float(rec_float),
    .alloc_reg(rec_reg), .alloc_addr(rec_addr),
    .kill_en(slot_kill), .kill_float(op_float), .kill_all(op_all), .kill_reg(op_reg),
    .slot_valid(slot_valid), .slot_float(slot_float),
    .slot_reg(slot_reg), .slot_addr(slot_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commit_exc <= 1'b0;
    else        commit_exc <= exc_d;
  end

  assert_exc_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_exc |-> $past(op_valid && tgt_ok && op_commit && log_valid && log_enable));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !tgt_ok) |=> (!commit_exc && $stable(ne_int) && $stable(ne_fp)
                               && $stable(slot_valid)));

  assert_nolog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !(log_valid && log_enable)) |=> (!commit_exc && $stable(slot_valid)));

  assert_other_type_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_float) |=> $stable(ne_int));

endmodule

// File: tb/dfc_commit_unit_tb.sv
module dfc_commit_unit_tb;

  localparam int NREG = 64, NSLOT = 4, AW = 32, RW = 6;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_commit = 0, op_float = 0, op_all = 0, tgt_ok = 1;
  logic hi_avail = 1, lo_avail = 1, log_valid = 1, log_enable = 1;
  logic rec_valid = 0, rec_float = 0;
  logic [RW-1:0] op_reg = '0, rec_reg = '0;
  logic [AW-1:0] rec_addr = '0;
  logic [NREG-1:0] ne_int, ne_fp;
  logic [NSLOT-1:0] slot_valid, slot_float;
  logic [NSLOT*RW-1:0] slot_reg;
  logic [NSLOT*AW-1:0] slot_addr;
  logic commit_exc;

  always #4 clk = ~clk;

  dfc_commit_unit u_dut (.*);

  // reference model
  logic [NREG-1:0] m_int, m_fp;
  logic m_v[NSLOT], m_f[NSLOT];
  int   m_r[NSLOT];
  logic [AW-1:0] m_a[NSLOT];
  logic m_exc;
  int checks = 0, fails = 0;
  string phase = "R1";

  task automatic chk(input string what, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", phase, what, got, exp);
    end
  endtask

  task automatic compare();
    logic [NSLOT*RW-1:0] er;
    logic [NSLOT*AW-1:0] ea;
    logic [NSLOT-1:0] ev, ef;
    for (int s = 0; s < NSLOT; s++) begin
      ev[s] = m_v[s]; ef[s] = m_f[s];
      er[s*RW +: RW] = RW'(m_r[s]); ea[s*AW +: AW] = m_a[s];
    end
    chk("ne_int", 256'(ne_int), 256'(m_int));
    chk("ne_fp", 256'(ne_fp), 256'(m_fp));
    chk("slot_valid", 256'(slot_valid), 256'(ev));
    chk("slot_float", 256'(slot_float), 256'(ef));
    chk("slot_reg", 256'(slot_reg), 256'(er));
    chk("slot_addr", 256'(slot_addr), 256'(ea));
    chk("commit_exc", 256'(commit_exc), 256'(m_exc));
  endtask

  task automatic model_reset();
    m_int = '0; m_fp = '0; m_exc = 0;
    for (int s = 0; s < NSLOT; s++) begin m_v[s] = 0; m_f[s] = 0; m_r[s] = 0; m_a[s] = '0; end
  endtask

  // one clock: model advances from the inputs, then outputs are compared
  task automatic cyc();
    logic la, pend, kill;
    logic [NREG-1:0] vec;
    la = log_valid && log_enable;
    m_exc = 0;
    if (op_valid) begin
      if (tgt_ok) begin
        vec = op_float ? m_fp : m_int;
        if (op_all) begin
          pend = (hi_avail && vec[63:32] != 0) || (lo_avail && vec[31:0] != 0);
          for (int r = 0; r < NREG; r++)
            if ((r >= 32 && hi_avail) || (r < 32 && lo_avail)) vec[r] = 0;
        end else begin
          pend = vec[op_reg];
          vec[op_reg] = 0;
        end
        if (op_float) m_fp = vec; else m_int = vec;
        kill = la && (!op_commit || pend);
        if (kill)
          for (int s = 0; s < NSLOT; s++)
            if (m_v[s] && m_f[s] == op_float && (op_all || m_r[s] == int'(op_reg))) begin
              m_v[s] = 0; m_f[s] = 0; m_r[s] = 0; m_a[s] = '0;
            end
        m_exc = op_commit && pend && la;
      end
    end else if (rec_valid) begin
      if (rec_float) m_fp[rec_reg] = 1; else m_int[rec_reg] = 1;
      if (la) begin
        for (int s = 0; s < NSLOT; s++)
          if (!m_v[s]) begin
            m_v[s] = 1; m_f[s] = rec_float; m_r[s] = int'(rec_reg); m_a[s] = rec_addr;
            break;
          end
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
    op_valid = 0; rec_valid = 0;
  endtask

  task automatic rec(input logic f, input int r, input logic [AW-1:0] a);
    rec_valid = 1; rec_float = f; rec_reg = RW'(r); rec_addr = a; cyc();
  endtask

  task automatic op(input logic cm, input logic f, input logic all, input int r);
    op_valid = 1; op_commit = cm; op_float = f; op_all = all; op_reg = RW'(r); cyc();
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    #20 @(negedge clk);
    phase = "R1"; compare();
    rst_n = 1;
    @(negedge clk);
    phase = "R2"; log_enable = 0;
    rec(0, 5, 32'h11); rec(1, 40, 32'h22);
    phase = "R3"; log_enable = 1;
    rec(0, 3, 32'hA0); rec(1, 40, 32'hA1); rec(0, 33, 32'hA2); rec(1, 63, 32'hA3);
    rec(0, 7, 32'hA4);                         // table full
    phase = "R2"; op_valid = 1; op_commit = 0; op_float = 1; op_all = 0; op_reg = 6'd9;
    rec_valid = 1; rec_float = 0; rec_reg = 6'd20; rec_addr = 32'hBB; cyc();
    phase = "R4"; op(0, 0, 0, 3);              // clear int 3, slot 0 freed
    phase = "R7"; op(1, 1, 0, 40);             // pending commit -> exc
    cyc();
    phase = "R8"; op(1, 1, 0, 40);             // nothing pending now
    rec(0, 33, 32'hC0);
    phase = "R9"; tgt_ok = 0; op(1, 0, 1, 0); tgt_ok = 1;
    phase = "R8"; log_valid = 0; op(1, 0, 0, 33); log_valid = 1;
    phase = "R10"; op(0, 1, 1, 0);
    rec(0, 2, 32'hD0); rec(0, 50, 32'hD1);
    phase = "R5"; hi_avail = 0; op(1, 0, 1, 0);  // lower half only
    hi_avail = 1; lo_avail = 0; op(1, 0, 1, 0);  // upper half only
    lo_avail = 1;
    phase = "R6"; rec(1, 12, 32'hE0); rec(1, 12, 32'hE1); op(0, 1, 0, 12);
    cyc();
    phase = "random";
    for (int n = 0; n < 400; n++) begin
      int pick[6] = '{0, 5, 31, 32, 40, 63};
      op_valid = ($urandom % 3) == 0; op_commit = $urandom; op_float = $urandom;
      op_all = ($urandom % 4) == 0; op_reg = RW'(pick[$urandom % 6]);
      tgt_ok = ($urandom % 10) != 0; hi_avail = $urandom; lo_avail = $urandom;
      log_valid = ($urandom % 6) != 0; log_enable = ($urandom % 6) != 0;
      rec_valid = $urandom; rec_float = $urandom; rec_reg = RW'(pick[$urandom % 6]);
      rec_addr = $urandom;
      cyc();
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule